// File: doc/BRIEF.md
# Octal Double-Buffered Code Register Decoder

This block sits between a serial receiver and eight 10-bit converters. Each channel keeps a staged code and a live code. The live code is the one the converter sees. The block receives complete 16-bit command words, each marked by a one-cycle valid strobe. The top four bits select the action. Actions include staging one channel, staging every channel, writing through to half or all of the channels, copying staged codes to live codes under a per-channel mask, clearing all codes, and handing a power command to a separate power controller.

Two asynchronous active-low lines come from outside. The load line passes through a synchronizer. While it is held low, every live code follows its staged code on each clock. The clear line zeroes every code register at the moment it falls, with no clock needed. A per-channel strobe marks each clock-driven change of a live code.

Top module: `octal_dac_regfile`

## Requirements
- R1: While `rst` is high, all live codes, staged codes, `upd_o`, `pwr_valid_o` and `shut_all_o` are cleared. All live codes read zero after reset.
- R2: Op field (word bits 15:12) 0x0 does nothing. No code changes and no strobe is raised, whatever the other bits hold.
- R3: Op 0x1 zeroes every staged and live code at the clock edge that samples the word. `shut_all_o` is high for the following cycle only.
- R4: Ops 0x2 to 0x9 write the data field (bits 11:2) into the staged code of channel op-1 (channel 1 to 8). Every live code stays unchanged.
- R5: Op 0xA writes the data into both the staged and live codes of channels 1 to 4. Op 0xB does the same for channels 5 to 8, and op 0xC for all eight channels. The new live value is visible in the cycle after the valid cycle.
- R6: Op 0xD writes the data into all eight staged codes. No live code changes.
- R7: Op 0xE copies staged to live for each channel whose mask bit is 1. The mask is bit 4 for channel 1 through bit 11 for channel 8. Channels with a 0 bit keep their live code.
- R8: The load line is synchronized through SYNC_STAGES flops. Once it has passed the synchronizer, each clock copies every staged code to its live code. A word that stages a value in that same clock reaches the live code at that clock edge.
- R9: When `clear_n_i` falls, every staged and live code is zeroed at once, with no clock edge. `shut_all_o` stays high while the line is low.
- R10: Op 0xF raises `pwr_valid_o` for one cycle. In that cycle `pwr_mask_o` holds word bits 11:4 and `pwr_mode_o` holds bits 3:2. No code register changes.
- R11: `upd_o[i]` is high for exactly the cycle after a clock edge that changed channel i's live code. A write that leaves the value the same raises no strobe.
- R12: Word bits 1:0 have no effect on any code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 16 | Command word from the serial receiver |
| word_valid_i | input | 1 | One-cycle strobe marking `word_i` valid |
| load_n_i | input | 1 | Asynchronous active-low transparent-load line |
| clear_n_i | input | 1 | Asynchronous active-low clear of all code registers |
| code_o | output | 80 | Live codes; channel n occupies bits [10n-1 : 10n-10] |
| upd_o | output | 8 | Per-channel strobe marking a changed live code |
| shut_all_o | output | 1 | Request to shut down all channels with the weak pull-down |
| pwr_valid_o | output | 1 | Power command strobe to the power controller |
| pwr_mask_o | output | 8 | Channel mask of the power command, bit 0 = channel 1 |
| pwr_mode_o | output | 2 | Mode field of the power command |

## Verification
The assertions check several properties on every clock:
- a write-through or masked copy lands the expected value in the live code;
- an input-only write leaves the live code still;
- a synchronized load makes the live code equal the staged code;
- an update strobe always goes with a real change of value;
- a power command freezes the codes;
- a clear command leaves every code at zero.

Some behaviours need the bench's scenarios:
- the exact decoding of each op value;
- the mask bit order;
- the latency of the load synchronizer;
- a word landing in the same cycle as the load;
- zeroing by the clear line without a clock;
- staged values that can only be seen after a later copy.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;

    localparam int NCH   = 8;
    localparam int CW    = 10;
    localparam int WORDW = 16;
    localparam int OPW   = 4;
    localparam int HALF  = NCH / 2;
    localparam int MODEW = 2;

    localparam int OP_LSB   = WORDW - OPW;
    localparam int DATA_LSB = OP_LSB - CW;
    localparam int MASK_LSB = OP_LSB - NCH;

    typedef enum logic [OPW-1:0] {
        OP_NOP     = 4'h0,
        OP_ZERO    = 4'h1,
        OP_STAGE1  = 4'h2,
        OP_STAGE8  = 4'h9,
        OP_WT_LO   = 4'hA,
        OP_WT_HI   = 4'hB,
        OP_WT_ALL  = 4'hC,
        OP_STG_ALL = 4'hD,
        OP_COPY    = 4'hE,
        OP_POWER   = 4'hF
    } opcode_e;

    typedef struct packed {
        logic [NCH-1:0]   stage_we;
        logic [NCH-1:0]   live_we;
        logic             zero_all;
        logic             pwr_fwd;
        logic [CW-1:0]    data;
        logic [NCH-1:0]   pmask;
        logic [MODEW-1:0] pmode;
    } cmd_t;

    function automatic logic [OPW-1:0] op_field(input logic [WORDW-1:0] w);
        return w[WORDW-1 -: OPW];
    endfunction

    function automatic logic [CW-1:0] data_field(input logic [WORDW-1:0] w);
        return w[DATA_LSB +: CW];
    endfunction

    function automatic logic [NCH-1:0] mask_field(input logic [WORDW-1:0] w);
        return w[MASK_LSB +: NCH];
    endfunction

    function automatic logic [MODEW-1:0] mode_field(input logic [WORDW-1:0] w);
        return w[MASK_LSB-1 -: MODEW];
    endfunction

endpackage

// File: rtl/dacreg_sync.sv
module dacreg_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/dacreg_decode.sv
module dacreg_decode
    import dacreg_pkg::*;
(
    input  logic [WORDW-1:0] word_i,
    input  logic             valid_i,
    output cmd_t             cmd_o
);

    opcode_e op;

    always_comb begin
        op                = opcode_e'(op_field(word_i));
        cmd_o             = '0;
        cmd_o.data        = data_field(word_i);
        cmd_o.pmask       = mask_field(word_i);
        cmd_o.pmode       = mode_field(word_i);
        if (valid_i) begin
            unique case (op)
                OP_NOP:     ;
                OP_ZERO:    cmd_o.zero_all = 1'b1;
                OP_WT_LO: begin
                    cmd_o.stage_we[HALF-1:0] = '1;
                    cmd_o.live_we[HALF-1:0]  = '1;
                end
                OP_WT_HI: begin
                    cmd_o.stage_we[NCH-1:HALF] = '1;
                    cmd_o.live_we[NCH-1:HALF]  = '1;
                end
                OP_WT_ALL: begin
                    cmd_o.stage_we = '1;
                    cmd_o.live_we  = '1;
                end
                OP_STG_ALL: cmd_o.stage_we = '1;
                OP_COPY:    cmd_o.live_we  = mask_field(word_i);
                OP_POWER:   cmd_o.pwr_fwd  = 1'b1;
                default: begin
                    for (int i = 0; i < NCH; i++) begin
                        if (op_field(word_i) == OPW'(int'(OP_STAGE1) + i))
                            cmd_o.stage_we[i] = 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/dacreg_chan.sv
module dacreg_chan
    import dacreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_n,
    input  logic          load_s,
    input  logic          stage_we,
    input  logic          live_we,
    input  logic          zero_all,
    input  logic [CW-1:0] data,
    output logic [CW-1:0] code_o,
    output logic          upd_o
);

    logic [CW-1:0] stage_q, stage_d;
    logic [CW-1:0] live_q, live_d;
    logic          upd_q;

    always_comb begin
        stage_d = stage_q;
        if (zero_all)      stage_d = '0;
        else if (stage_we) stage_d = data;

        live_d = live_q;
        if (zero_all)                live_d = '0;
        else if (load_s || live_we)  live_d = stage_d;
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            stage_q <= '0;
            live_q  <= '0;
            upd_q   <= 1'b0;
        end else if (rst) begin
            stage_q <= '0;
            live_q  <= '0;
            upd_q   <= 1'b0;
        end else begin
            stage_q <= stage_d;
            live_q  <= live_d;
            upd_q   <= (live_d != live_q);
        end
    end

    assign code_o = live_q;
    assign upd_o  = upd_q;

    AST_WT_LANDS: assert property (@(posedge clk) disable iff (rst || !clear_n)
        (live_we && stage_we && !zero_all) |=> (live_q == $past(data))); // R5

    AST_COPY_LANDS: assert property (@(posedge clk) disable iff (rst || !clear_n)
        (live_we && !stage_we && !zero_all) |=> (live_q == $past(stage_q))); // R7

    AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (rst || !clear_n)
        (stage_we && !live_we && !load_s && !zero_all) |=> $stable(live_q)); // R4

    AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (rst || !clear_n)
        (load_s && !zero_all) |=> (live_q == stage_q)); // R8

    AST_UPD_REAL: assert property (@(posedge clk) disable iff (rst || !clear_n)
        upd_q |-> (live_q != $past(live_q))); // R11

endmodule

// File: rtl/octal_dac_regfile.sv
module octal_dac_regfile
    import dacreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WORDW-1:0]   word_i,
    input  logic               word_valid_i,
    input  logic               load_n_i,
    input  logic               clear_n_i,
    output logic [NCH*CW-1:0]  code_o,
    output logic [NCH-1:0]     upd_o,
    output logic               shut_all_o,
    output logic               pwr_valid_o,
    output logic [NCH-1:0]     pwr_mask_o,
    output logic [MODEW-1:0]   pwr_mode_o
);

    cmd_t cmd;
    logic load_n_s;
    logic load_s;
    logic shut_q;

    dacreg_decode u_dec (
        .word_i  (word_i),
        .valid_i (word_valid_i),
        .cmd_o   (cmd)
    );

    dacreg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_load_sync (
        .clk (clk),
        .rst (rst),
        .d   (load_n_i),
        .q   (load_n_s)
    );

    assign load_s = ~load_n_s;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dacreg_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .clear_n  (clear_n_i),
            .load_s   (load_s),
            .stage_we (cmd.stage_we[g]),
            .live_we  (cmd.live_we[g]),
            .zero_all (cmd.zero_all),
            .data     (cmd.data),
            .code_o   (code_o[g*CW +: CW]),
            .upd_o    (upd_o[g])
        );
    end

    always_ff @(posedge clk or negedge clear_n_i) begin
        if (!clear_n_i)  shut_q <= 1'b1;
        else if (rst)    shut_q <= 1'b0;
        else             shut_q <= cmd.zero_all;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_valid_o <= 1'b0;
            pwr_mask_o  <= '0;
            pwr_mode_o  <= '0;
        end else begin
            pwr_valid_o <= cmd.pwr_fwd;
            if (cmd.pwr_fwd) begin
                pwr_mask_o <= cmd.pmask;
                pwr_mode_o <= cmd.pmode;
            end
        end
    end

    assign shut_all_o = shut_q;

    AST_PWR_FREEZE: assert property (@(posedge clk) disable iff (rst || !clear_n_i)
        (pwr_valid_o && !$past(load_s)) |-> $stable(code_o)); // R10

    AST_ZERO_CMD: assert property (@(posedge clk) disable iff (rst || !clear_n_i)
        (shut_all_o && !$past(!clear_n_i)) |-> (code_o == '0)); // R3

endmodule

// File: tb/octal_dac_regfile_tb.sv
module octal_dac_regfile_tb;

    localparam int NC = 8;
    localparam int W  = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic [15:0]       word_i;
    logic              word_valid_i;
    logic              load_n_i;
    logic              clear_n_i;
    logic [NC*W-1:0]   code_o;
    logic [NC-1:0]     upd_o;
    logic              shut_all_o;
    logic              pwr_valid_o;
    logic [NC-1:0]     pwr_mask_o;
    logic [1:0]        pwr_mode_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    octal_dac_regfile u_dut (
        .clk          (clk),
        .rst          (rst),
        .word_i       (word_i),
        .word_valid_i (word_valid_i),
        .load_n_i     (load_n_i),
        .clear_n_i    (clear_n_i),
        .code_o       (code_o),
        .upd_o        (upd_o),
        .shut_all_o   (shut_all_o),
        .pwr_valid_o  (pwr_valid_o),
        .pwr_mask_o   (pwr_mask_o),
        .pwr_mode_o   (pwr_mode_o)
    );

    function automatic logic [W-1:0] ch(input int n);
        return code_o[(n-1)*W +: W];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_codes(input string req, input logic [W-1:0] exp [NC]);
        for (int i = 1; i <= NC; i++) check(req, 32'(ch(i)), 32'(exp[i-1]));
    endtask

    task automatic send(input logic [3:0] op, input logic [11:0] body);
        @(negedge clk);
        word_i       = {op, body};
        word_valid_i = 1'b1;
        @(negedge clk);
        word_valid_i = 1'b0;
        word_i       = 16'h0;
    endtask

    function automatic logic [11:0] dat(input logic [9:0] d);
        return {d, 2'b00};
    endfunction

    logic [W-1:0] exp_c [NC];

    task automatic t_reset();
        for (int i = 0; i < NC; i++) exp_c[i] = '0;
        check_codes("R1 reset codes", exp_c);
        check("R1 reset upd", 32'(upd_o), 32'h0);
        check("R1 reset shut", 32'(shut_all_o), 32'h0);
        check("R1 reset pwr", 32'(pwr_valid_o), 32'h0);
    endtask

    task automatic t_stage_one();
        send(4'h4, dat(10'h155));
        check("R4 live kept after stage ch3", 32'(ch(3)), 32'h0);
        check("R4 no strobe", 32'(upd_o), 32'h0);
        send(4'hE, {8'b0000_0100, 4'h0});
        exp_c[2] = 10'h155;
        check_codes("R7 copy ch3", exp_c);
        check("R11 strobe ch3", 32'(upd_o), 32'h04);
    endtask

    task automatic t_write_through();
        send(4'hA, dat(10'h3FF));
        for (int i = 0; i < 4; i++) exp_c[i] = 10'h3FF;
        check_codes("R5 lower half", exp_c);
        check("R11 lower strobe", 32'(upd_o), 32'h0F);
        send(4'hB, dat(10'h001));
        for (int i = 4; i < 8; i++) exp_c[i] = 10'h001;
        check_codes("R5 upper half", exp_c);
        check("R11 upper strobe", 32'(upd_o), 32'hF0);
        send(4'hC, dat(10'h200));
        for (int i = 0; i < 8; i++) exp_c[i] = 10'h200;
        check_codes("R5 all", exp_c);
        check("R11 all strobe", 32'(upd_o), 32'hFF);
        send(4'hC, dat(10'h200));
        check("R11 same value no strobe", 32'(upd_o), 32'h00);
    endtask

    task automatic t_broadcast_copy();
        send(4'hD, dat(10'h0AA));
        check_codes("R6 broadcast stage keeps live", exp_c);
        check("R6 no strobe", 32'(upd_o), 32'h0);
        send(4'hE, {8'h81, 4'h0});
        exp_c[0] = 10'h0AA;
        exp_c[7] = 10'h0AA;
        check_codes("R7 mask order ch8 and ch1", exp_c);
        check("R7 strobe", 32'(upd_o), 32'h81);
    endtask

    task automatic t_nop();
        send(4'h0, 12'hFFF);
        check_codes("R2 nop", exp_c);
        check("R2 nop strobe", 32'(upd_o), 32'h0);
    endtask

    task automatic t_low_bits();
        send(4'h3, {10'h123, 2'b11});
        send(4'hE, {8'b0000_0010, 4'h0});
        exp_c[1] = 10'h123;
        check_codes("R12 low bits ignored", exp_c);
    endtask

    task automatic t_power();
        @(negedge clk);
        word_i       = {4'hF, 8'hA5, 2'b10, 2'b00};
        word_valid_i = 1'b1;
        @(negedge clk);
        word_valid_i = 1'b0;
        check("R10 pwr valid", 32'(pwr_valid_o), 32'h1);
        check("R10 pwr mask", 32'(pwr_mask_o), 32'hA5);
        check("R10 pwr mode", 32'(pwr_mode_o), 32'h2);
        check_codes("R10 codes kept", exp_c);
        @(negedge clk);
        check("R10 pwr one cycle", 32'(pwr_valid_o), 32'h0);
    endtask

    task automatic t_load();
        send(4'hD, dat(10'h0F0));
        load_n_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_codes("R8 sync latency", exp_c);
        @(negedge clk);
        for (int i = 0; i < 8; i++) exp_c[i] = 10'h0F0;
        check_codes("R8 transparent", exp_c);
        check("R8 strobe", 32'(upd_o), 32'hFF);
        send(4'h6, dat(10'h3C3));
        exp_c[4] = 10'h3C3;
        check_codes("R8 same-cycle stage", exp_c);
        check("R11 strobe ch5", 32'(upd_o), 32'h10);
        load_n_i = 1'b1;
        repeat (3) @(negedge clk);
        send(4'h6, dat(10'h111));
        check_codes("R8 released", exp_c);
    endtask

    task automatic t_zero_cmd();
        send(4'h1, 12'h000);
        for (int i = 0; i < 8; i++) exp_c[i] = '0;
        check_codes("R3 zero cmd live", exp_c);
        check("R3 shut pulse", 32'(shut_all_o), 32'h1);
        @(negedge clk);
        check("R3 shut one cycle", 32'(shut_all_o), 32'h0);
        send(4'hE, {8'hFF, 4'h0});
        check_codes("R3 staged zeroed", exp_c);
    endtask

    task automatic t_clear();
        send(4'hC, dat(10'h155));
        @(negedge clk);
        #2 clear_n_i = 1'b0;
        #1;
        for (int i = 0; i < 8; i++) exp_c[i] = '0;
        check_codes("R9 async clear", exp_c);
        check("R9 shut while low", 32'(shut_all_o), 32'h1);
        @(negedge clk);
        clear_n_i = 1'b1;
        @(negedge clk);
        check("R9 shut drops", 32'(shut_all_o), 32'h0);
        send(4'hE, {8'hFF, 4'h0});
        check_codes("R9 staged cleared", exp_c);
    endtask

    initial begin
        rst          = 1'b1;
        word_i       = 16'h0;
        word_valid_i = 1'b0;
        load_n_i     = 1'b1;
        clear_n_i    = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_stage_one();
        t_write_through();
        t_broadcast_copy();
        t_nop();
        t_low_bits();
        t_power();
        t_load();
        t_zero_cmd();
        t_clear();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule